// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block produces a single pulse of a set length when a trigger is seen. The length is a count of clock cycles taken from a width input, so no external timing parts are needed. There are two trigger inputs of opposite polarity. One fires on a falling edge and the other on a rising edge, and each input enables the other. The result drives a true output and its complement.

An active-low clear ends any pulse and keeps the block idle for as long as it is held. Releasing the clear does not start a pulse by itself. However, a trigger edge seen in the same cycle as the release is accepted. A mode input chooses how triggers that arrive during a pulse are handled. In the retriggerable mode they restart the timing. In the other mode they are ignored.

All three asynchronous inputs pass through two-flop synchronisers. Edge detection and timing work on the synchronised levels. Q therefore rises two clock edges after the edge that first samples the new trigger level.

Top module: `retrig_oneshot`

## Requirements
- R1: A falling edge on `fire_fall_n` while `fire_rise` is LOW starts a pulse: `q` is HIGH for exactly `width` clock cycles.
- R2: A rising edge on `fire_rise` while `fire_fall_n` is HIGH starts a pulse of exactly `width` cycles.
- R3: A falling edge on `fire_fall_n` while `fire_rise` is HIGH, or a rising edge on `fire_rise` while `fire_fall_n` is LOW, starts no pulse.
- R4: With `hold_mode` LOW, an accepted trigger during a pulse reloads the timing. `q` stays HIGH without a gap and falls `width` cycles after the last trigger.
- R5: With `hold_mode` HIGH, triggers that arrive while `q` is HIGH are ignored. A trigger after the pulse has ended starts a new pulse.
- R6: While `clr_n` is LOW, `q` is forced LOW no later than the third clock edge after the change. It stays LOW with no spike, whatever the triggers do.
- R7: A LOW-to-HIGH change on `clr_n` with no trigger edge starts no pulse.
- R8: A trigger edge that reaches the synchroniser output in the same cycle as the rising `clr_n` is accepted and starts a pulse of `width` cycles.
- R9: `q_n` is always the inverse of `q`.
- R10: A `width` of 0 is treated as 1, giving a one-cycle pulse.
- R11: After synchronous reset, `q` is LOW and `q_n` is HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fire_fall_n | input | 1 | Trigger on falling edge; enables the rising trigger while HIGH |
| fire_rise | input | 1 | Trigger on rising edge; enables the falling trigger while LOW |
| clr_n | input | 1 | Active-low direct clear |
| hold_mode | input | 1 | 1 = ignore triggers during a pulse, 0 = retrigger |
| width | input | WIDTH_BITS | Pulse length in clock cycles (0 acts as 1) |
| q | output | 1 | True pulse output |
| q_n | output | 1 | Complementary pulse output |

## Verification
The main function is tried with single triggers on each input across several widths, including 0 and 1. This shows that both edge polarities reach the same timer, and it pins the exact length count. Second triggers placed inside and outside a running pulse, in both modes, separate reload from ignore. They also show that a late trigger in the ignore mode still starts a new pulse. The gated-edge, clear-held, release-only and release-with-trigger patterns separate clear priority from the rule that lets a coincident trigger through.

// File: rtl/os_pkg.sv
`timescale 1ns/1ps
package os_pkg;
  typedef struct packed {
    logic fall_n;
    logic rise;
    logic clr_n;
  } os_in_t;

  localparam os_in_t OS_IDLE = '{fall_n: 1'b1, rise: 1'b0, clr_n: 1'b0};
endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
module os_sync #(
  parameter int STAGES = 2,
  parameter int BITS   = 3,
  parameter logic [BITS-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [BITS-1:0] stage [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[k] <= RST_VAL;
          else     stage[k] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[k] <= RST_VAL;
          else     stage[k] <= stage[k-1];
        end
      end
    end
  endgenerate

  assign dout = stage[LAST];
endmodule

// File: rtl/os_trig_qual.sv
`timescale 1ns/1ps
module os_trig_qual
  import os_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  os_in_t lvl,
  output logic   fire
);
  os_in_t prev;
  logic   fall_hit;
  logic   rise_hit;

  always_ff @(posedge clk) begin
    if (rst) prev <= OS_IDLE;
    else     prev <= lvl;
  end

  // falling edge counts only while the other input is low, rising only while the other is high
  assign fall_hit = prev.fall_n & ~lvl.fall_n & ~lvl.rise;
  assign rise_hit = ~prev.rise & lvl.rise & lvl.fall_n;
  // a releasing clear is already high here, so a coincident edge passes
  assign fire     = (fall_hit | rise_hit) & lvl.clr_n;

  // R1, R2: no trigger without a change of a trigger level
  p_edge_needed_r1: assert property (@(posedge clk) disable iff (rst)
    fire |-> ((lvl.fall_n != prev.fall_n) || (lvl.rise != prev.rise)));
  // R6: no trigger while clear is held
  p_clear_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    !lvl.clr_n |-> !fire);
endmodule

// File: rtl/os_timer.sv
`timescale 1ns/1ps
module os_timer #(
  parameter int WIDTH_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_ok,
  input  logic                  fire,
  input  logic                  hold,
  input  logic [WIDTH_BITS-1:0] width,
  output logic                  pulse,
  output logic                  pulse_n
);
  localparam logic [WIDTH_BITS-1:0] ONE = WIDTH_BITS'(1);

  logic [WIDTH_BITS-1:0] cnt;
  logic [WIDTH_BITS-1:0] reload;
  logic                  accept;

  assign reload = (width == '0) ? '0 : width - ONE;
  assign accept = fire & ~(hold & pulse);

  always_ff @(posedge clk) begin
    if (rst || !clr_ok) begin
      pulse   <= 1'b0;
      pulse_n <= 1'b1;
      cnt     <= '0;
    end else if (accept) begin
      pulse   <= 1'b1;
      pulse_n <= 1'b0;
      cnt     <= reload;
    end else if (pulse) begin
      if (cnt == '0) begin
        pulse   <= 1'b0;
        pulse_n <= 1'b1;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  p_qn_inverse_r9: assert property (@(posedge clk) disable iff (rst)
    pulse_n == ~pulse);
  p_clear_forces_low_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_ok |=> !pulse);
  p_start_needs_trigger_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(fire));
  p_ends_at_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (pulse && cnt == '0 && !accept && clr_ok) |=> !pulse);
  p_hold_counts_down_r5: assert property (@(posedge clk) disable iff (rst)
    (hold && pulse && cnt != '0 && clr_ok) |=> (pulse && cnt == $past(cnt) - ONE));
  p_retrig_keeps_high_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && clr_ok) |=> pulse);
endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
module retrig_oneshot
  import os_pkg::*;
#(
  parameter int WIDTH_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fire_fall_n,
  input  logic                  fire_rise,
  input  logic                  clr_n,
  input  logic                  hold_mode,
  input  logic [WIDTH_BITS-1:0] width,
  output logic                  q,
  output logic                  q_n
);
  localparam int IN_BITS = $bits(os_in_t);

  os_in_t raw;
  os_in_t lvl;
  logic   fire;

  assign raw = '{fall_n: fire_fall_n, rise: fire_rise, clr_n: clr_n};

  os_sync #(.STAGES(SYNC_STAGES), .BITS(IN_BITS), .RST_VAL(OS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .dout(lvl)
  );

  os_trig_qual u_qual (
    .clk (clk),
    .rst (rst),
    .lvl (lvl),
    .fire(fire)
  );

  os_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr_ok (lvl.clr_n),
    .fire   (fire),
    .hold   (hold_mode),
    .width  (width),
    .pulse  (q),
    .pulse_n(q_n)
  );

  p_reset_idle_r11: assert property (@(posedge clk)
    $past(rst) |-> (!q && q_n));
endmodule

// File: tb/retrig_oneshot_tb_top.sv
`timescale 1ns/1ps
module retrig_oneshot_tb_top;
  localparam int WB = 16;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fire_fall_n = 1'b1;
  logic fire_rise = 1'b0;
  logic clr_n = 1'b1;
  logic hold_mode = 1'b0;
  logic [WB-1:0] width = '0;
  logic q, q_n;

  int n_chk = 0;
  int n_bad = 0;
  int qn_bad = 0;
  bit run = 1'b0;

  always #5 clk = ~clk;

  retrig_oneshot #(.WIDTH_BITS(WB)) dut_i (
    .clk(clk), .rst(rst), .fire_fall_n(fire_fall_n), .fire_rise(fire_rise),
    .clr_n(clr_n), .hold_mode(hold_mode), .width(width), .q(q), .q_n(q_n)
  );

  // fields: kind (0 fall on fire_fall_n, 1 rise on fire_rise), width, hold, second-trigger delay (0 none), expected high cycles
  localparam logic [39:0] VEC [NV] = '{
    {8'd0, 8'd5,  8'd0, 8'd0,  8'd5},   // R1
    {8'd1, 8'd8,  8'd0, 8'd0,  8'd8},   // R2
    {8'd0, 8'd1,  8'd0, 8'd0,  8'd1},   // R1
    {8'd1, 8'd0,  8'd0, 8'd0,  8'd1},   // R10
    {8'd1, 8'd12, 8'd0, 8'd6,  8'd18},  // R4
    {8'd0, 8'd10, 8'd0, 8'd4,  8'd14},  // R4
    {8'd0, 8'd4,  8'd0, 8'd8,  8'd8},   // R4 separate pulses
    {8'd0, 8'd10, 8'd1, 8'd4,  8'd10},  // R5
    {8'd1, 8'd6,  8'd1, 8'd4,  8'd6},   // R5
    {8'd1, 8'd3,  8'd1, 8'd10, 8'd6},   // R5 late trigger accepted
    {8'd0, 8'd0,  8'd1, 8'd0,  8'd1}    // R10
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) if (run && (q_n !== ~q)) qn_bad++;

  task automatic drive(input int kind, input bit on);
    if (kind == 0) fire_fall_n = ~on;
    else           fire_rise   = on;
  endtask

  // run a window of n cycles, trigger at 0 and optionally at d, count q-high cycles
  task automatic window(input int kind, input int d, input int n, output int highs);
    highs = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (q === 1'b1) highs++;
      if (c == 0 || (d != 0 && c == d))         drive(kind, 1'b1);
      if (c == 2 || (d != 0 && c == d + 2))     drive(kind, 1'b0);
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (q === 1'b1) highs++;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int h;
    idle(4);
    rst = 1'b0;
    run = 1'b1;
    @(negedge clk);
    chk("R11 q", int'(q), 0);
    chk("R11 q_n", int'(q_n), 1);

    for (int v = 0; v < NV; v++) begin
      logic [39:0] e;
      e = VEC[v];
      width     = e[31:24];
      hold_mode = e[23:16];
      window(int'(e[39:32]), int'(e[15:8]), int'(e[31:24]) + int'(e[15:8]) + 12, h);
      chk($sformatf("R1/R2/R4/R5/R10 vec%0d", v), h, int'(e[7:0]));
      idle(3);
    end

    // R3 gated falling edge: set fire_rise high under clear
    width = 6; hold_mode = 0;
    clr_n = 0; idle(2); fire_rise = 1; idle(4); clr_n = 1; idle(4);
    fire_fall_n = 0;
    count_high(12, h);
    chk("R3 gated fall", h, 0);
    fire_fall_n = 1; idle(4); fire_rise = 0;
    count_high(8, h);
    chk("R3 restore quiet", h, 0);

    // R3 gated rising edge
    clr_n = 0; idle(2); fire_fall_n = 0; idle(4); clr_n = 1; idle(4);
    fire_rise = 1;
    count_high(12, h);
    chk("R3 gated rise", h, 0);
    fire_fall_n = 1; idle(4); fire_rise = 0; idle(4);

    // R6 clear cuts a running pulse
    width = 40;
    window(0, 0, 6, h);
    chk("R6 pulse running", int'(q), 1);
    clr_n = 0;
    idle(3);
    chk("R6 cut by clear", int'(q), 0);
    h = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (q === 1'b1) h++;
      if (c % 3 == 0) fire_fall_n = ~fire_fall_n;
      if (c % 4 == 1) fire_rise   = ~fire_rise;
    end
    fire_fall_n = 1; fire_rise = 0;
    count_high(5, h);
    chk("R6 no spike under clear", h, 0);

    // R7 release alone
    width = 5;
    clr_n = 1;
    count_high(12, h);
    chk("R7 release only", h, 0);

    // R8 release together with a trigger
    clr_n = 0; idle(5);
    clr_n = 1; fire_fall_n = 0;
    count_high(12, h);
    chk("R8 coincident trigger", h, 5);
    fire_fall_n = 1; idle(4);

    chk("R9 q_n mismatches", qn_bad, 0);
    finish_run();
  end
endmodule